// File: doc/BRIEF.md
# Three-Channel Wiper Register Command Slave

This block is the register and command side of a three-channel digital potentiometer that is controlled over a two-wire serial bus. It holds two 9-bit wiper registers and one 7-bit wiper register. Each working register has a nonvolatile shadow copy. The shadow space also holds eleven bytes of general storage and six read-only calibration bytes that give each channel's end-to-end tolerance. A separate bit engine detects start and stop conditions and shifts bytes. It delivers start and stop pulses, received bytes and read requests to this block. The block answers each received byte with an acknowledge decision and serves read bytes from an auto-incrementing pointer.

After the device address, the first written byte is an instruction. With its top bit clear, the instruction selects the working or shadow space and sets a 5-bit pointer, and any following data bytes are written there. With its top bit set, the instruction carries a 4-bit opcode and a 3-bit channel field. The opcode restores from the shadow copy, stores to it, or passes a step or shift request to an external adjust unit. Any write into the shadow space is followed by an internal write interval. During that interval the block does not acknowledge its own address, so the host polls with address bytes until one is acknowledged.

Top module: `wpot_slave`

## Requirements
- R1: The device address is the 7-bit value 0101,1,dev_sel[1],dev_sel[0], carried in bits 7..1 of the first byte after a start; bit 0 is 1 for read and 0 for write. A matching address is acknowledged (ack=1 with ack_stb). A mismatch is not acknowledged, and every further byte up to the next start is also answered with ack=0.
- R2: In a write, an instruction byte with bit 7 = 0 loads the pointer: bit 6 picks the space (0 working, 1 shadow) and bits 4..0 the address. Each data byte that follows is written at the pointer, and the pointer then advances by one, wrapping within 5 bits. Instruction and data bytes are acknowledged.
- R3: Working map: address 0 holds wiper_a[7:0], 1 holds wiper_a[8] in bit 0, 2 holds wiper_b[7:0], 3 holds wiper_b[8] in bit 0, and 4 holds wiper_c[6:0]. The unused bits of these bytes read as 0. Writes to other addresses are ignored, and those addresses read 0.
- R4: In a read, tx_byte shows the byte at the pointer, and each tx_req advances the pointer. A read that follows a stop continues from wherever the pointer stood. A random read is an instruction-only write, a repeated start, and then a read.
- R5: Shadow space addresses 0..4 hold the stored wiper values in the R3 layout, and addresses 5..15 are general user bytes. After power-up reset, the stored and working wipers are 256, 256 and 64, and the user bytes are 0.
- R6: Shadow addresses 24..29 return the tolerance bytes TOL_BYTES[7:0] up to TOL_BYTES[47:40]. Each channel has a sign-magnitude integer byte followed by a fraction byte. Writes to these addresses are acknowledged and leave them unchanged.
- R7: A command byte is 1,code[3:0],chan[2:0]. Code 2 copies the selected working wiper to its shadow copy. Code 1 restores the selected wiper from its shadow copy, and code 7 restores all three.
- R8: Codes 10, 5, 8 and 3 dispatch increment, decrement, double and halve for one channel. Codes 11, 6, 9 and 4 dispatch the same four operations for all channels. Dispatch is a one-cycle adj_valid with adj_op (0 increment, 1 decrement, 2 double, 3 halve) and adj_mask (one-hot channel, or 111 for all). A channel field above 2, code 0 and codes 12..15 dispatch nothing.
- R9: When a stop ends a transaction that wrote the shadow space or stored a wiper, address bytes are not acknowledged for WRITE_CYCLES clock cycles. After that, they are acknowledged again.
- R10: While wp_n is low, data writes in either space, store commands and adjust dispatches have no effect, and no write interval starts. Bytes are still acknowledged, and restore commands still reload the working wipers.
- R11: While reload_n is low, every working wiper is reloaded from its shadow copy on each clock.
- R12: Bytes that follow a command byte in the same transaction are acknowledged and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-up reset, active low; loads all defaults |
| reload_n | input | 1 | Hardware reload, active low; copies shadow wipers to working wipers |
| wp_n | input | 1 | Write protect, active low |
| dev_sel | input | 2 | Low two bits of the device address |
| bus_start | input | 1 | One-cycle pulse on a start or repeated start |
| bus_stop | input | 1 | One-cycle pulse on a stop |
| rx_valid | input | 1 | One-cycle strobe: rx_byte holds a byte written by the host |
| rx_byte | input | 8 | Byte received from the host |
| ack_stb | output | 1 | One-cycle strobe after each rx_valid |
| ack | output | 1 | Acknowledge decision, valid with ack_stb |
| tx_req | input | 1 | Host consumed tx_byte; advance the pointer |
| tx_byte | output | 8 | Byte at the pointer for the current read |
| adj_valid | output | 1 | One-cycle adjust request |
| adj_op | output | 2 | Adjust operation: 0 inc, 1 dec, 2 double, 3 halve |
| adj_mask | output | 3 | Channels to adjust |
| wiper_a | output | WIDE_BITS | Working wiper of channel 0 |
| wiper_b | output | WIDE_BITS | Working wiper of channel 1 |
| wiper_c | output | NARROW_BITS | Working wiper of channel 2 |

## Verification
The address decoder is driven with a matching byte, a mismatching byte, and a matching byte sent during a write interval. These three cases separate a correct match from acknowledgements that come too freely or too late. Register traffic covers a multi-byte write that runs through the 9-bit high bytes, the reserved gap in the map, and a random read that steps across that gap. It also covers a current-address read, so that pointer advance, field placement and masking of unused bits can each be told apart. Commands are tried for every action class, with a single channel, with all channels and with an out-of-range channel. A write-protected pass repeats the same writes, stores and adjust requests, showing which paths protection blocks and which restore paths it leaves open.

// File: rtl/wpot_pkg.sv
package wpot_pkg;
   localparam int NUM_CH    = 3;
   localparam int ADDR_W    = 5;
   localparam int USER_BASE = 5;
   localparam int TOL_BASE  = 24;
   localparam int TOL_COUNT = 2 * NUM_CH;

   localparam logic [3:0] DEV_PREFIX = 4'b0101;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_INSTR,
      PH_WDATA,
      PH_RDATA,
      PH_DRAIN
   } phase_t;

   typedef enum logic [1:0] {
      ADJ_INC  = 2'd0,
      ADJ_DEC  = 2'd1,
      ADJ_DBL  = 2'd2,
      ADJ_HALF = 2'd3
   } adj_op_t;

   typedef struct packed {
      logic              shadow;
      logic [ADDR_W-1:0] addr;
   } ptr_t;
endpackage

// File: rtl/wpot_cmd_decode.sv
module wpot_cmd_decode
   import wpot_pkg::*;
(
   input  logic [7:0]        instr,
   output logic              is_cmd,
   output logic [NUM_CH-1:0] restore_mask,
   output logic [NUM_CH-1:0] store_mask,
   output logic [NUM_CH-1:0] adj_mask,
   output adj_op_t           adj_op
);
   logic [3:0]        code;
   logic [2:0]        chan;
   logic [NUM_CH-1:0] one;

   always_comb begin
      is_cmd = instr[7];
      code   = instr[6:3];
      chan   = instr[2:0];
      for (int c = 0; c < NUM_CH; c++) one[c] = (32'(chan) == c);
      restore_mask = '0;
      store_mask   = '0;
      adj_mask     = '0;
      adj_op       = ADJ_INC;
      if (is_cmd) begin
         case (code)
            4'd1:  restore_mask = one;
            4'd2:  store_mask   = one;
            4'd3:  begin adj_op = ADJ_HALF; adj_mask = one; end
            4'd4:  begin adj_op = ADJ_HALF; adj_mask = '1;  end
            4'd5:  begin adj_op = ADJ_DEC;  adj_mask = one; end
            4'd6:  begin adj_op = ADJ_DEC;  adj_mask = '1;  end
            4'd7:  restore_mask = '1;
            4'd8:  begin adj_op = ADJ_DBL;  adj_mask = one; end
            4'd9:  begin adj_op = ADJ_DBL;  adj_mask = '1;  end
            4'd10: begin adj_op = ADJ_INC;  adj_mask = one; end
            4'd11: begin adj_op = ADJ_INC;  adj_mask = '1;  end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/wpot_bank.sv
module wpot_bank
   import wpot_pkg::*;
#(
   parameter  int WIDE   = 9,
   parameter  int NARROW = 7,
   localparam int VW     = NUM_CH * WIDE
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic [NUM_CH-1:0] load_mask,
   input  logic [VW-1:0]     load_val,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic [VW-1:0]     val
);
   if (WIDE < 9 || WIDE > 16) begin : g_bad_wide
      $error("wpot_bank: WIDE must lie in 9..16");
   end
   if (NARROW < 1 || NARROW > 8) begin : g_bad_narrow
      $error("wpot_bank: NARROW must lie in 1..8");
   end

   logic [7:0] rd_part [NUM_CH];

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam int W = (ch == NUM_CH - 1) ? NARROW : WIDE;
      localparam logic [ADDR_W-1:0] LO = ADDR_W'(2 * ch);
      logic [W-1:0] r;
      logic [W-1:0] wr_val;

      if (W > 8) begin : g_two_byte
         always_comb begin
            wr_val = r;
            if (wr_addr == LO)        wr_val[7:0]   = wr_data;
            if (wr_addr == LO + 1'b1) wr_val[W-1:8] = wr_data[W-9:0];
         end
         assign rd_part[ch] = (rd_addr == LO)        ? r[7:0] :
                              (rd_addr == LO + 1'b1) ? 8'(r[W-1:8]) : 8'h00;
      end else begin : g_one_byte
         logic [WIDE-W-1:0] unused_hi;
         assign unused_hi   = load_val[ch*WIDE+W +: WIDE-W];
         assign wr_val      = (wr_addr == LO) ? wr_data[W-1:0] : r;
         assign rd_part[ch] = (rd_addr == LO) ? 8'(r) : 8'h00;
      end

      always_ff @(posedge clk) begin
         if (!por_n)             r <= {1'b1, {(W-1){1'b0}}};
         else if (load_mask[ch]) r <= load_val[ch*WIDE +: W];
         else if (wr_en)         r <= wr_val;
      end

      assign val[ch*WIDE +: WIDE] = WIDE'(r);
   end

   always_comb begin
      rd_data = '0;
      for (int c = 0; c < NUM_CH; c++) rd_data |= rd_part[c];
   end
endmodule

// File: rtl/wpot_nvm_aux.sv
module wpot_nvm_aux
   import wpot_pkg::*;
#(
   parameter  int                     USER_BYTES   = 11,
   parameter  int                     WRITE_CYCLES = 200,
   parameter  logic [8*TOL_COUNT-1:0] TOL_BYTES    = 48'h10_03_80_81_40_02,
   localparam int                     CW           = $clog2(WRITE_CYCLES + 1),
   localparam int                     IW           = $clog2(USER_BYTES)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   input  logic              kick,
   output logic              busy
);
   if (USER_BYTES < 2 || USER_BASE + USER_BYTES > TOL_BASE) begin : g_bad_user
      $error("wpot_nvm_aux: user bytes overlap the tolerance bytes");
   end
   if (WRITE_CYCLES < 1) begin : g_bad_wait
      $error("wpot_nvm_aux: WRITE_CYCLES must be at least 1");
   end

   localparam logic [ADDR_W-1:0] USER_LO = ADDR_W'(USER_BASE);
   localparam logic [ADDR_W-1:0] USER_HI = ADDR_W'(USER_BASE + USER_BYTES - 1);
   localparam logic [ADDR_W-1:0] TOL_LO  = ADDR_W'(TOL_BASE);
   localparam logic [ADDR_W-1:0] TOL_HI  = ADDR_W'(TOL_BASE + TOL_COUNT - 1);

   logic [7:0]    user [USER_BYTES];
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!por_n) begin
         for (int i = 0; i < USER_BYTES; i++) user[i] <= '0;
      end else if (wr_en && wr_addr >= USER_LO && wr_addr <= USER_HI) begin
         user[IW'(wr_addr - USER_LO)] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!por_n)          cnt <= '0;
      else if (kick)       cnt <= CW'(WRITE_CYCLES);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end
   assign busy = (cnt != '0);

   always_comb begin
      rd_data = '0;
      if (rd_addr >= USER_LO && rd_addr <= USER_HI)
         rd_data = user[IW'(rd_addr - USER_LO)];
      else if (rd_addr >= TOL_LO && rd_addr <= TOL_HI)
         rd_data = TOL_BYTES[8*int'(rd_addr - TOL_LO) +: 8];
   end

   assert_kick_loads_busy_R9: assert property (@(posedge clk) disable iff (!por_n)
      kick |=> busy);
   assert_busy_from_kick_R9: assert property (@(posedge clk) disable iff (!por_n)
      $rose(busy) |-> $past(kick));
endmodule

// File: rtl/wpot_slave.sv
module wpot_slave
   import wpot_pkg::*;
#(
   parameter int                     WIDE_BITS    = 9,
   parameter int                     NARROW_BITS  = 7,
   parameter int                     USER_BYTES   = 11,
   parameter int                     WRITE_CYCLES = 200,
   parameter logic [8*TOL_COUNT-1:0] TOL_BYTES    = 48'h10_03_80_81_40_02
) (
   input  logic                   clk,
   input  logic                   por_n,
   input  logic                   reload_n,
   input  logic                   wp_n,
   input  logic [1:0]             dev_sel,
   input  logic                   bus_start,
   input  logic                   bus_stop,
   input  logic                   rx_valid,
   input  logic [7:0]             rx_byte,
   output logic                   ack_stb,
   output logic                   ack,
   input  logic                   tx_req,
   output logic [7:0]             tx_byte,
   output logic                   adj_valid,
   output logic [1:0]             adj_op,
   output logic [NUM_CH-1:0]      adj_mask,
   output logic [WIDE_BITS-1:0]   wiper_a,
   output logic [WIDE_BITS-1:0]   wiper_b,
   output logic [NARROW_BITS-1:0] wiper_c
);
   localparam int VW = NUM_CH * WIDE_BITS;

   phase_t            phase;
   ptr_t              ptr;
   logic              pend;
   adj_op_t           adj_op_q;
   logic [6:0]        dev_addr;
   logic              byte_ok, cmd_fire, wr_fire;
   logic              dec_is_cmd;
   logic [NUM_CH-1:0] dec_restore, dec_store, dec_adj;
   adj_op_t           dec_op;
   logic [NUM_CH-1:0] wk_load, sh_load;
   logic [VW-1:0]     wk_val, sh_val;
   logic [7:0]        wk_rd, sh_rd, aux_rd;
   logic              nvm_busy, kick;

   assign dev_addr = {DEV_PREFIX, 1'b1, dev_sel};
   assign byte_ok  = rx_valid && !bus_start && !bus_stop;
   assign cmd_fire = byte_ok && phase == PH_INSTR && dec_is_cmd;
   assign wr_fire  = byte_ok && phase == PH_WDATA && wp_n;
   assign wk_load  = (cmd_fire ? dec_restore : '0) | (reload_n ? '0 : '1);
   assign sh_load  = (cmd_fire && wp_n) ? dec_store : '0;
   assign kick     = bus_stop && pend;

   wpot_cmd_decode i_decode (
      .instr(rx_byte), .is_cmd(dec_is_cmd), .restore_mask(dec_restore),
      .store_mask(dec_store), .adj_mask(dec_adj), .adj_op(dec_op)
   );

   wpot_bank #(.WIDE(WIDE_BITS), .NARROW(NARROW_BITS)) i_work (
      .clk, .por_n, .load_mask(wk_load), .load_val(sh_val),
      .wr_en(wr_fire && !ptr.shadow), .wr_addr(ptr.addr), .wr_data(rx_byte),
      .rd_addr(ptr.addr), .rd_data(wk_rd), .val(wk_val)
   );

   wpot_bank #(.WIDE(WIDE_BITS), .NARROW(NARROW_BITS)) i_shadow (
      .clk, .por_n, .load_mask(sh_load), .load_val(wk_val),
      .wr_en(wr_fire && ptr.shadow), .wr_addr(ptr.addr), .wr_data(rx_byte),
      .rd_addr(ptr.addr), .rd_data(sh_rd), .val(sh_val)
   );

   wpot_nvm_aux #(.USER_BYTES(USER_BYTES), .WRITE_CYCLES(WRITE_CYCLES), .TOL_BYTES(TOL_BYTES)) i_aux (
      .clk, .por_n, .wr_en(wr_fire && ptr.shadow), .wr_addr(ptr.addr), .wr_data(rx_byte),
      .rd_addr(ptr.addr), .rd_data(aux_rd), .kick, .busy(nvm_busy)
   );

   always_ff @(posedge clk) begin
      if (!por_n) begin
         phase     <= PH_IDLE;
         ptr       <= '0;
         pend      <= 1'b0;
         ack_stb   <= 1'b0;
         ack       <= 1'b0;
         adj_valid <= 1'b0;
         adj_op_q  <= ADJ_INC;
         adj_mask  <= '0;
      end else begin
         ack_stb   <= 1'b0;
         ack       <= 1'b0;
         adj_valid <= 1'b0;
         if (bus_stop) begin
            phase <= PH_IDLE;
            pend  <= 1'b0;
         end else if (bus_start) begin
            phase <= PH_ADDR;
         end else if (rx_valid) begin
            ack_stb <= 1'b1;
            case (phase)
               PH_ADDR: begin
                  if (rx_byte[7:1] == dev_addr && !nvm_busy) begin
                     ack   <= 1'b1;
                     phase <= rx_byte[0] ? PH_RDATA : PH_INSTR;
                  end else begin
                     phase <= PH_IDLE;
                  end
               end
               PH_INSTR: begin
                  ack <= 1'b1;
                  if (dec_is_cmd) begin
                     phase     <= PH_DRAIN;
                     adj_valid <= wp_n && (dec_adj != '0);
                     adj_op_q  <= dec_op;
                     adj_mask  <= dec_adj;
                     if (wp_n && dec_store != '0) pend <= 1'b1;
                  end else begin
                     ptr   <= '{shadow: rx_byte[6], addr: rx_byte[4:0]};
                     phase <= PH_WDATA;
                  end
               end
               PH_WDATA: begin
                  ack      <= 1'b1;
                  ptr.addr <= ptr.addr + 1'b1;
                  if (wp_n && ptr.shadow) pend <= 1'b1;
               end
               PH_DRAIN: ack <= 1'b1;
               default:  ack <= 1'b0;
            endcase
         end else if (tx_req && phase == PH_RDATA) begin
            ptr.addr <= ptr.addr + 1'b1;
         end
      end
   end

   assign tx_byte = ptr.shadow ? (sh_rd | aux_rd) : wk_rd;
   assign adj_op  = adj_op_q;
   assign wiper_a = wk_val[0 +: WIDE_BITS];
   assign wiper_b = wk_val[WIDE_BITS +: WIDE_BITS];
   assign wiper_c = wk_val[2*WIDE_BITS +: NARROW_BITS];

   assert_addr_mismatch_nack_R1: assert property (@(posedge clk) disable iff (!por_n)
      (byte_ok && phase == PH_ADDR && rx_byte[7:1] != dev_addr) |=> (ack_stb && !ack));
   assert_busy_nack_R9: assert property (@(posedge clk) disable iff (!por_n)
      (byte_ok && phase == PH_ADDR && nvm_busy) |=> (ack_stb && !ack));
   assert_protect_holds_wipers_R10: assert property (@(posedge clk) disable iff (!por_n)
      (!wp_n && reload_n && !(cmd_fire && dec_restore != '0)) |=> $stable(wk_val));
   assert_protect_holds_shadow_R10: assert property (@(posedge clk) disable iff (!por_n)
      (!wp_n) |=> $stable(sh_val));
   assert_adjust_gated_R8: assert property (@(posedge clk) disable iff (!por_n)
      adj_valid |-> ($past(wp_n) && adj_mask != '0));
   assert_ack_only_strobed_R1: assert property (@(posedge clk) disable iff (!por_n)
      ack |-> ack_stb);
endmodule

// File: tb/test_wpot_slave.sv
module test_wpot_slave;
   localparam int WR_CYC = 200;

   logic       clk = 1'b0;
   logic       por_n = 1'b0, reload_n = 1'b1, wp_n = 1'b1;
   logic [1:0] dev_sel = 2'b10;
   logic       bus_start = 1'b0, bus_stop = 1'b0, rx_valid = 1'b0, tx_req = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       ack_stb, ack, adj_valid;
   logic [7:0] tx_byte;
   logic [1:0] adj_op;
   logic [2:0] adj_mask;
   logic [8:0] wiper_a, wiper_b;
   logic [6:0] wiper_c;

   int vectors = 0;
   int miscompares = 0;

   bit    exp_ack_q[$];
   string ack_tag_q[$];
   int    exp_adj_q[$];
   string adj_tag_q[$];

   always #2 clk = ~clk;

   wpot_slave #(.WRITE_CYCLES(WR_CYC)) i_wpot_slave (
      .clk, .por_n, .reload_n, .wp_n, .dev_sel, .bus_start, .bus_stop,
      .rx_valid, .rx_byte, .ack_stb, .ack, .tx_req, .tx_byte,
      .adj_valid, .adj_op, .adj_mask, .wiper_a, .wiper_b, .wiper_c
   );

   task automatic check(string tag, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bstart();
      bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
   endtask

   task automatic bstop();
      bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
   endtask

   task automatic sendb(logic [7:0] b, bit exp_ack, string tag);
      exp_ack_q.push_back(exp_ack);
      ack_tag_q.push_back(tag);
      rx_byte = b; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic rdb(int exp, string tag);
      check(tag, int'(tx_byte), exp);
      tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
   endtask

   task automatic expect_adj(int val, string tag);
      exp_adj_q.push_back(val);
      adj_tag_q.push_back(tag);
   endtask

   task automatic wr1(logic [7:0] instr, logic [7:0] d, string tag);
      bstart(); sendb(8'h5C, 1, tag); sendb(instr, 1, tag); sendb(d, 1, tag); bstop();
   endtask

   task automatic cmd(logic [7:0] c, string tag);
      bstart(); sendb(8'h5C, 1, tag); sendb(c, 1, tag); bstop();
   endtask

   task automatic seek_read(logic [7:0] instr, string tag);
      bstart(); sendb(8'h5C, 1, tag); sendb(instr, 1, tag);
      bstart(); sendb(8'h5D, 1, tag);
   endtask

   // scoreboard monitor: pops expected acknowledge and dispatch items
   always @(negedge clk) begin
      if (ack_stb) begin
         if (exp_ack_q.size() == 0) check("unexpected ack strobe", 1, 0);
         else check(ack_tag_q.pop_front(), int'(ack), int'(exp_ack_q.pop_front()));
      end
      if (adj_valid) begin
         if (exp_adj_q.size() == 0) check("R8 unexpected adjust dispatch", int'({adj_op, adj_mask}), 0);
         else check(adj_tag_q.pop_front(), int'({adj_op, adj_mask}), exp_adj_q.pop_front());
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      tick(4);
      por_n = 1'b1;
      tick(1);
      // R5 reset state
      check("R5 reset wiper_a", wiper_a, 256);
      check("R5 reset wiper_b", wiper_b, 256);
      check("R5 reset wiper_c", wiper_c, 64);
      check("R8 reset adj_valid", adj_valid, 0);

      // R1 mismatching address, following byte also nacked
      bstart(); sendb(8'h58, 0, "R1 mismatch addr"); sendb(8'h00, 0, "R1 after mismatch"); bstop();
      check("R1 no write after mismatch", wiper_a, 256);

      // R2 R3 multi-byte write through the map
      bstart(); sendb(8'h5C, 1, "R1 match addr"); sendb(8'h00, 1, "R2 instr");
      sendb(8'h34, 1, "R2 d0"); sendb(8'h01, 1, "R2 d1"); sendb(8'h78, 1, "R2 d2");
      sendb(8'h00, 1, "R2 d3"); sendb(8'hFF, 1, "R2 d4"); sendb(8'h99, 1, "R3 reserved write");
      bstop();
      check("R2 wiper_a", wiper_a, 9'h134);
      check("R2 wiper_b", wiper_b, 9'h078);
      check("R3 wiper_c masked", wiper_c, 7'h7F);

      // R4 random read from address 1 across reserved space
      seek_read(8'h01, "R4 seek");
      rdb(8'h01, "R3 rd a hi"); rdb(8'h78, "R3 rd b lo"); rdb(8'h00, "R3 rd b hi");
      rdb(8'h7F, "R3 rd c bit7 zero"); rdb(8'h00, "R3 rd reserved");
      bstop();
      // R4 current-address read continues after a seek to address 0
      seek_read(8'h00, "R4 seek0"); rdb(8'h34, "R4 rd a lo"); bstop();
      bstart(); sendb(8'h5D, 1, "R4 current addr"); rdb(8'h01, "R4 current read"); bstop();

      // R5 shadow defaults
      seek_read(8'h40, "R5 seek");
      rdb(8'h00, "R5 sh a lo"); rdb(8'h01, "R5 sh a hi"); rdb(8'h00, "R5 sh b lo");
      rdb(8'h01, "R5 sh b hi"); rdb(8'h40, "R5 sh c"); rdb(8'h00, "R5 user default");
      bstop();

      // R6 tolerance bytes
      seek_read(8'h58, "R6 seek");
      rdb(8'h02, "R6 tol0"); rdb(8'h40, "R6 tol1"); rdb(8'h81, "R6 tol2");
      rdb(8'h80, "R6 tol3"); rdb(8'h03, "R6 tol4"); rdb(8'h10, "R6 tol5");
      bstop();

      // R9 user write, then polling
      bstart(); sendb(8'h5C, 1, "R5 addr"); sendb(8'h45, 1, "R5 instr");
      sendb(8'hA5, 1, "R5 user5"); sendb(8'h5A, 1, "R5 user6"); bstop();
      bstart(); sendb(8'h5C, 0, "R9 busy nack"); bstop();
      tick(WR_CYC + 4);
      seek_read(8'h45, "R9 ack after interval");
      rdb(8'hA5, "R5 user5 read"); rdb(8'h5A, "R5 user6 read"); bstop();

      // R6 write to read-only byte is acked and discarded
      wr1(8'h58, 8'hEE, "R6 ro write ack");
      tick(WR_CYC + 4);
      seek_read(8'h58, "R6 seek again"); rdb(8'h02, "R6 ro unchanged"); bstop();

      // R7 store channel 0
      cmd(8'h90, "R7 store ch0");
      bstart(); sendb(8'h5C, 0, "R9 busy after store"); bstop();
      tick(WR_CYC + 4);
      seek_read(8'h40, "R7 seek sh");
      rdb(8'h34, "R7 stored lo"); rdb(8'h01, "R7 stored hi"); bstop();

      // R7 restore one and all
      wr1(8'h00, 8'h05, "R7 set a");
      check("R7 a written", wiper_a, 9'h105);
      cmd(8'h88, "R7 restore ch0");
      check("R7 restore ch0", wiper_a, 9'h134);
      check("R7 restore ch0 leaves b", wiper_b, 9'h078);
      cmd(8'hB8, "R7 restore all");
      check("R7 restore all b", wiper_b, 256);
      check("R7 restore all c", wiper_c, 64);
      check("R7 restore all a", wiper_a, 9'h134);

      // R8 R12 adjust dispatch
      expect_adj(5'b00_010, "R8 inc ch1");
      bstart(); sendb(8'h5C, 1, "R8 addr"); sendb(8'hD1, 1, "R8 inc cmd");
      sendb(8'h33, 1, "R12 trailing byte"); bstop();
      check("R12 trailing byte no effect", wiper_b, 256);
      check("R12 trailing byte no effect a", wiper_a, 9'h134);
      expect_adj(5'b11_111, "R8 halve all");
      cmd(8'hA0, "R8 halve all cmd");
      expect_adj(5'b01_100, "R8 dec ch2");
      cmd(8'hAA, "R8 dec ch2 cmd");
      expect_adj(5'b10_111, "R8 double all");
      cmd(8'hC8, "R8 double all cmd");
      cmd(8'h9D, "R8 bad channel none");
      cmd(8'hE8, "R8 reserved code none");
      cmd(8'h80, "R8 nop none");

      // R10 write protect
      wr1(8'h00, 8'h02, "R10 pre set a");
      check("R10 pre a", wiper_a, 9'h102);
      wp_n = 1'b0;
      wr1(8'h00, 8'h77, "R10 wp write acked");
      check("R10 wp write blocked", wiper_a, 9'h102);
      wr1(8'h45, 8'h00, "R10 wp shadow write");
      cmd(8'hD0, "R10 wp adjust none");
      cmd(8'h90, "R10 wp store none");
      seek_read(8'h40, "R10 no interval");
      rdb(8'h34, "R10 store blocked"); bstop();
      seek_read(8'h45, "R10 seek user"); rdb(8'hA5, "R10 user unchanged"); bstop();
      cmd(8'h88, "R10 wp restore");
      check("R10 restore allowed", wiper_a, 9'h134);
      wp_n = 1'b1;

      // R11 hardware reload
      wr1(8'h04, 8'h05, "R11 set c");
      wr1(8'h02, 8'h09, "R11 set b");
      check("R11 c written", wiper_c, 7'h05);
      reload_n = 1'b0; tick(2); reload_n = 1'b1; tick(1);
      check("R11 reload c", wiper_c, 64);
      check("R11 reload b", wiper_b, 256);
      check("R11 reload a", wiper_a, 9'h134);

      tick(3);
      check("scoreboard ack queue drained", exp_ack_q.size(), 0);
      check("R8 scoreboard adjust queue drained", exp_adj_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule